// File: doc/BRIEF.md
# Packed Unsigned Byte Compare Unit

This block decodes and executes a four-lane packed compare. Each cycle it may accept one 32-bit instruction word, together with a flag that chooses the standard or the compact encoding and the two 32-bit operand values already read from the register file. The first operand (the value of the `rs` register) is split into four unsigned 8-bit lanes. Each lane is compared with the same lane of the second operand (the value of the `rt` register). The comparison is equality, unsigned less-than or unsigned less-or-equal, as the instruction word selects.

The four one-bit results land in a 4-bit slice, bits 27..24, of the condition-code byte of a 32-bit DSP control register held inside the block. Every other bit of that register keeps its value.

A word that matches neither encoding for the three conditions raises a reserved-instruction flag. A legal compare issued while the DSP-enable input is low raises a DSP-disabled flag. Each flag lasts one cycle, and the register is not written when either is raised.

A small outcome state machine records what the most recent clock edge did. Its states are:
- `ST_IDLE`: no request.
- `ST_WROTE`: the compare slice was updated.
- `ST_RSVD`: the word was rejected as reserved.
- `ST_DSPOFF`: the compare was refused because the DSP is disabled.

Transitions happen on every rising edge:
- No valid request goes to `ST_IDLE`.
- A valid request with an illegal word goes to `ST_RSVD`.
- A valid legal request with the DSP disabled goes to `ST_DSPOFF`.
- A valid legal request with the DSP enabled goes to `ST_WROTE`.

Reset forces `ST_IDLE`.

Top module: `pbc_unit`

## Requirements
- R1: Condition equal sets a lane's result bit when the two unsigned bytes of that lane are identical.
- R2: Condition less-than sets a lane's result bit when the first-operand byte is strictly below the second-operand byte as unsigned numbers, so 0x7F is below 0x80.
- R3: Condition less-or-equal sets a lane's result bit when the first-operand byte is below or equal to the second-operand byte, unsigned.
- R4: Lane bits 31..24 writes control bit 27, lane 23..16 writes bit 26, lane 15..8 writes bit 25 and lane 7..0 writes bit 24. The update appears on `ctrl_o` after the rising edge on which `valid_i` is high.
- R5: Control bits 31..28 and 23..0 are never changed by any request.
- R6: Standard encoding (`compact_i`=0) has the following fields. The `rs` index is bits 25..21 and the `rt` index is bits 20..16.
  - Bits 31..26 are 011111 and bits 5..0 are 010001.
  - Bits 15..11 are 00000.
  - Bits 10..6 select the condition: 00000 equal, 00001 less-than, 00010 less-or-equal.
- R7: Compact encoding (`compact_i`=1) has the following fields. The `rt` index is bits 25..21 and the `rs` index is bits 20..16.
  - Bits 31..26 are 000000 and bits 15..10 are zero.
  - Bits 9..0 select the condition: 1001000101 equal, 1010000101 less-than, 1011000101 less-or-equal.
- R8: A valid word that matches neither encoding sets `rsvd_o` for exactly one cycle and leaves `ctrl_o` unchanged. This holds regardless of `dsp_en_i`, because reserved takes priority.
- R9: A valid legal word with `dsp_en_i` low sets `dsp_off_o` for exactly one cycle and leaves `ctrl_o` unchanged.
- R10: With `valid_i` low, `ctrl_o` keeps its value and neither flag is raised.
- R11: Synchronous reset clears `ctrl_o` to zero and both flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe |
| compact_i | input | 1 | 1 selects the compact encoding |
| insn_i | input | 32 | Instruction word |
| opa_i | input | 32 | Value of the rs register (first operand) |
| opb_i | input | 32 | Value of the rt register (second operand) |
| dsp_en_i | input | 1 | DSP enable |
| ctrl_o | output | 32 | DSP control register |
| rsvd_o | output | 1 | Reserved-instruction flag, one cycle |
| dsp_off_o | output | 1 | DSP-disabled flag, one cycle |
| rs_idx_o | output | 5 | Decoded rs index (combinational) |
| rt_idx_o | output | 5 | Decoded rt index (combinational) |

## Verification
A wrong outcome state, such as a flag stuck high or the wrong flag for a refused compare, is visible on `rsvd_o` or `dsp_off_o` in the cycle right after the offending edge. It is also visible when a flag stays up into the following idle cycle. A wrong control-register value shows on `ctrl_o` one edge after the request, as a swapped lane, a signed-compare result or a write that should have been blocked. Because the register holds its value, such an error keeps showing until the next successful compare. The index outputs show a field-order mistake combinationally, before the edge.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
    typedef enum logic [1:0] {
        CMP_EQ = 2'd0,
        CMP_LT = 2'd1,
        CMP_LE = 2'd2
    } cmp_cond_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WROTE  = 2'd1,
        ST_RSVD   = 2'd2,
        ST_DSPOFF = 2'd3
    } pbc_state_e;

    localparam logic [5:0] STD_MAJOR  = 6'b011111;
    localparam logic [5:0] STD_MINOR  = 6'b010001;
    localparam logic [5:0] CPT_MAJOR  = 6'b000000;
    localparam logic [9:0] CPT_EQ     = 10'b1001000101;
    localparam logic [9:0] CPT_LT     = 10'b1010000101;
    localparam logic [9:0] CPT_LE     = 10'b1011000101;
endpackage

// File: rtl/pbc_decoder.sv
module pbc_decoder
    import pbc_pkg::*;
(
    input  logic [31:0] insn,
    input  logic        compact,
    output logic        legal,
    output cmp_cond_e   cond,
    output logic [4:0]  rs_idx,
    output logic [4:0]  rt_idx
);
    logic      std_frame, cpt_frame;
    logic      std_code_ok, cpt_code_ok;
    cmp_cond_e std_cond, cpt_cond;

    assign std_frame = (insn[31:26] == STD_MAJOR) && (insn[15:11] == 5'd0)
                       && (insn[5:0] == STD_MINOR);
    assign cpt_frame = (insn[31:26] == CPT_MAJOR) && (insn[15:10] == 6'd0);

    always_comb begin
        std_code_ok = 1'b1;
        std_cond    = CMP_EQ;
        unique case (insn[10:6])
            5'd0:    std_cond = CMP_EQ;
            5'd1:    std_cond = CMP_LT;
            5'd2:    std_cond = CMP_LE;
            default: std_code_ok = 1'b0;
        endcase
    end

    always_comb begin
        cpt_code_ok = 1'b1;
        cpt_cond    = CMP_EQ;
        unique case (insn[9:0])
            CPT_EQ:  cpt_cond = CMP_EQ;
            CPT_LT:  cpt_cond = CMP_LT;
            CPT_LE:  cpt_cond = CMP_LE;
            default: cpt_code_ok = 1'b0;
        endcase
    end

    always_comb begin
        if (compact) begin
            legal  = cpt_frame && cpt_code_ok;
            cond   = cpt_cond;
            rt_idx = insn[25:21];
            rs_idx = insn[20:16];
        end else begin
            legal  = std_frame && std_code_ok;
            cond   = std_cond;
            rs_idx = insn[25:21];
            rt_idx = insn[20:16];
        end
    end
endmodule

// File: rtl/pbc_lane_cmp.sv
module pbc_lane_cmp
    import pbc_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  cmp_cond_e         cond,
    output logic              hit
);
    always_comb begin
        unique case (cond)
            CMP_EQ:  hit = (a == b);
            CMP_LT:  hit = (a < b);
            CMP_LE:  hit = (a <= b);
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/pbc_unit.sv
module pbc_unit
    import pbc_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int CC_LSB = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     valid_i,
    input  logic                     compact_i,
    input  logic [31:0]              insn_i,
    input  logic [LANES*LANE_W-1:0]  opa_i,
    input  logic [LANES*LANE_W-1:0]  opb_i,
    input  logic                     dsp_en_i,
    output logic [LANES*LANE_W-1:0]  ctrl_o,
    output logic                     rsvd_o,
    output logic                     dsp_off_o,
    output logic [4:0]               rs_idx_o,
    output logic [4:0]               rt_idx_o
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int CC_MSB = CC_LSB + LANES - 1;

    logic             legal;
    cmp_cond_e        cond;
    logic [LANES-1:0] lane_hit;
    pbc_state_e       state_q, state_d;
    logic [DATA_W-1:0] ctrl_q;

    pbc_decoder u_dec (
        .insn    (insn_i),
        .compact (compact_i),
        .legal   (legal),
        .cond    (cond),
        .rs_idx  (rs_idx_o),
        .rt_idx  (rt_idx_o)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pbc_lane_cmp #(.LANE_W(LANE_W)) u_cmp (
            .a    (opa_i[g*LANE_W +: LANE_W]),
            .b    (opb_i[g*LANE_W +: LANE_W]),
            .cond (cond),
            .hit  (lane_hit[g])
        );
    end

    // next outcome state
    always_comb begin
        if (!valid_i)       state_d = ST_IDLE;
        else if (!legal)    state_d = ST_RSVD;
        else if (!dsp_en_i) state_d = ST_DSPOFF;
        else                state_d = ST_WROTE;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)                      ctrl_q <= '0;
        else if (state_d == ST_WROTE) ctrl_q[CC_MSB:CC_LSB] <= lane_hit;
    end

    // outputs
    always_comb begin
        rsvd_o    = 1'b0;
        dsp_off_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_WROTE:  ;
            ST_RSVD:   rsvd_o    = 1'b1;
            ST_DSPOFF: dsp_off_o = 1'b1;
            default:   ;
        endcase
    end
    assign ctrl_o = ctrl_q;

    // R8 / R9: a refusal never changes the register
    a_r8_rsvd_no_write: assert property (@(posedge clk) disable iff (rst)
        rsvd_o |-> $stable(ctrl_o));
    a_r9_off_no_write: assert property (@(posedge clk) disable iff (rst)
        dsp_off_o |-> $stable(ctrl_o));
    // R10: no request, no flag and no change
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!rsvd_o && !dsp_off_o && $stable(ctrl_o)));
    // R5: bits outside the compare slice hold
    a_r5_hold_upper: assert property (@(posedge clk) disable iff (rst)
        $stable(ctrl_o[DATA_W-1:CC_MSB+1]));
    a_r5_hold_lower: assert property (@(posedge clk) disable iff (rst)
        $stable(ctrl_o[CC_LSB-1:0]));
    // R8 / R9: flags exclusive
    a_r8_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsvd_o, dsp_off_o}));
endmodule

// File: tb/pbc_unit_bench.sv
module pbc_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i, compact_i, dsp_en_i;
    logic [31:0] insn_i, opa_i, opb_i;
    logic [31:0] ctrl_o;
    logic        rsvd_o, dsp_off_o;
    logic [4:0]  rs_idx_o, rt_idx_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;
    logic [31:0] exp_ctrl;

    always #4 clk = ~clk;

    pbc_unit u_pbc_unit (
        .clk(clk), .rst(rst), .valid_i(valid_i), .compact_i(compact_i),
        .insn_i(insn_i), .opa_i(opa_i), .opb_i(opb_i), .dsp_en_i(dsp_en_i),
        .ctrl_o(ctrl_o), .rsvd_o(rsvd_o), .dsp_off_o(dsp_off_o),
        .rs_idx_o(rs_idx_o), .rt_idx_o(rt_idx_o)
    );

    function automatic logic [31:0] std_word(input logic [4:0] rs, input logic [4:0] rt,
                                             input logic [4:0] code);
        return {6'b011111, rs, rt, 5'b00000, code, 6'b010001};
    endfunction

    function automatic logic [31:0] cpt_word(input logic [4:0] rs, input logic [4:0] rt,
                                             input int c);
        logic [9:0] code;
        code = (c == 0) ? 10'b1001000101 : (c == 1) ? 10'b1010000101 : 10'b1011000101;
        return {6'b000000, rt, rs, 6'b000000, code};
    endfunction

    // c: 0 equal, 1 less-than, 2 less-or-equal
    function automatic logic [3:0] model_cc(input int c, input logic [31:0] a,
                                            input logic [31:0] b);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) begin
            int x, y;
            x = int'(a[i*8 +: 8]);
            y = int'(b[i*8 +: 8]);
            r[i] = (c == 0) ? (x == y) : (c == 1) ? (x < y) : (x <= y);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // issue one request at a negedge, check at the next negedge
    task automatic issue(input string req, input logic cpt, input logic [31:0] w,
                         input logic [31:0] a, input logic [31:0] b, input logic en,
                         input logic legal, input int c,
                         input logic [4:0] rs, input logic [4:0] rt);
        valid_i = 1; compact_i = cpt; insn_i = w; opa_i = a; opb_i = b; dsp_en_i = en;
        #1;
        check({req, " rs index"}, {27'd0, rs_idx_o}, {27'd0, rs});
        check({req, " rt index"}, {27'd0, rt_idx_o}, {27'd0, rt});
        @(posedge clk);
        @(negedge clk);
        valid_i = 0;
        if (legal && en) exp_ctrl[27:24] = model_cc(c, a, b);
        check({req, " ctrl"}, ctrl_o, exp_ctrl);
        check({req, " rsvd"}, {31'd0, rsvd_o}, {31'd0, !legal});
        check({req, " dsp_off"}, {31'd0, dsp_off_o}, {31'd0, legal && !en});
    endtask

    initial begin
        for (int n = 0; n < 150000; n++) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; valid_i = 0; compact_i = 0; insn_i = 0; opa_i = 0; opb_i = 0; dsp_en_i = 1;
        exp_ctrl = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R11 reset ctrl", ctrl_o, 32'd0);
        check("R11 reset flags", {30'd0, rsvd_o, dsp_off_o}, 32'd0);

        // R1 equal, standard, lane mapping R4
        issue("R1 R4 std eq", 0, std_word(5'd3, 5'd9, 5'd0), 32'h11_22_33_44,
              32'h11_00_33_00, 1, 1, 0, 5'd3, 5'd9);
        check("R4 lane 31..24 to bit 27", {31'd0, ctrl_o[27]}, 32'd1);
        // R2 unsigned less-than: 0x7F < 0x80, 0xFF not < 0x00
        issue("R2 std lt", 0, std_word(5'd1, 5'd2, 5'd1), 32'h7F_FF_00_05,
              32'h80_00_01_05, 1, 1, 1, 5'd1, 5'd2);
        check("R2 lane 31..24 unsigned", {28'd0, ctrl_o[27:24]}, 32'h0000000A);
        // R3 less-or-equal compact, R7 field order
        issue("R3 R7 cpt le", 1, cpt_word(5'd4, 5'd17, 2), 32'h10_20_30_40,
              32'h10_1F_31_40, 1, 1, 2, 5'd4, 5'd17);
        check("R3 le pattern", {28'd0, ctrl_o[27:24]}, 32'h0000000B);
        issue("R1 R7 cpt eq", 1, cpt_word(5'd30, 5'd0, 0), 32'hAA_BB_CC_DD,
              32'hAA_BB_CC_DD, 1, 1, 0, 5'd30, 5'd0);
        issue("R2 R7 cpt lt", 1, cpt_word(5'd7, 5'd8, 1), 32'h00_00_00_00,
              32'h01_00_FF_00, 1, 1, 1, 5'd7, 5'd8);
        // R6 standard le code
        issue("R3 R6 std le", 0, std_word(5'd31, 5'd5, 5'd2), 32'hFF_00_80_01,
              32'hFF_01_7F_00, 1, 1, 2, 5'd31, 5'd5);
        // R8 reserved: bad condition code, bad minor, bad compact zero field
        issue("R8 std code 3", 0, std_word(5'd1, 5'd1, 5'd3), 32'h0, 32'h0,
              1, 0, 0, 5'd1, 5'd1);
        @(negedge clk);
        check("R8 flag one cycle", {31'd0, rsvd_o}, 32'd0);
        issue("R8 std minor", 0, std_word(5'd2, 5'd6, 5'd0) ^ 32'h1, 32'h0, 32'h0,
              1, 0, 0, 5'd2, 5'd6);
        issue("R8 cpt bit10", 1, cpt_word(5'd2, 5'd6, 0) | 32'h400, 32'h0, 32'h0,
              0, 0, 0, 5'd2, 5'd6);
        issue("R8 cpt word as std", 0, cpt_word(5'd9, 5'd10, 1), 32'h0, 32'h1,
              1, 0, 0, 5'd10, 5'd9);
        // R9 DSP disabled
        issue("R9 off", 0, std_word(5'd1, 5'd2, 5'd0), 32'h0, 32'h0, 0, 1, 0, 5'd1, 5'd2);
        @(negedge clk);
        check("R9 flag one cycle", {31'd0, dsp_off_o}, 32'd0);
        // R10 idle with changing inputs
        insn_i = std_word(5'd1, 5'd2, 5'd0); opa_i = 32'h0; opb_i = 32'hFFFFFFFF;
        @(negedge clk);
        check("R10 idle ctrl", ctrl_o, exp_ctrl);
        check("R10 idle flags", {30'd0, rsvd_o, dsp_off_o}, 32'd0);

        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [4:0]  rs, rt;
            logic [31:0] a, b, w;
            logic        cpt, en, legal;
            int          c;
            rs = 5'($urandom); rt = 5'($urandom);
            cpt = 1'($urandom); en = ($urandom % 8) != 0;
            c = int'($urandom % 3);
            a = $urandom; b = $urandom;
            for (int i = 0; i < 4; i++) if ($urandom % 3 == 0) b[i*8 +: 8] = a[i*8 +: 8];
            w = cpt ? cpt_word(rs, rt, c) : std_word(rs, rt, 5'(c));
            legal = 1;
            if ($urandom % 10 == 0) begin
                w[15] = 1'b1; legal = 0;
            end
            issue(legal ? (c == 0 ? "R1 rand" : c == 1 ? "R2 rand" : "R3 rand") : "R8 rand",
                  cpt, w, a, b, en, legal, c, rs, rt);
            check("R5 rand untouched bits", ctrl_o & 32'hF0FF_FFFF, 32'd0);
        end

        // R11 reset from a nonzero value
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        rst = 0;
        exp_ctrl = 0;
        check("R11 reset again", ctrl_o, 32'd0);
        finish_run();
    end
endmodule